// File: doc/BRIEF.md
# Single-Line Bus Bit-Slot Master

This block is the timing engine of a master on a single-wire, open-drain serial bus with a pull-up resistor. A host issues one command at a time: a bus reset with detection of a device's presence answer, a write of 1 to 8 bits, a read of 1 to 8 bits, or a release of the strong pull-up. The block generates each time slot from a microsecond tick. The tick comes from a clock-divider parameter, so the same code runs at any system clock. Bits travel least significant first. The assembled read value and the presence flag are returned on ports.

The pad is modelled as two controls and one input. `busDrvLow` pulls the wire to ground. `busPullHi` drives the wire actively high. `busIn` is the sampled wire level. The strong pull-up exists to feed parasitically powered devices after a write. It switches on only after the final slot of a write that requested it. It stays on until the next command of any kind is accepted.

Top module: `owm_master`

## Requirements
- R1: A reset command holds `busDrvLow` high for exactly RST_LOW_US microseconds, starting the cycle after acceptance. It then releases the line for RST_REL_US microseconds before the command completes.
- R2: `presence` is cleared when a reset is accepted. It is set only if, during the first PRES_WIN_US microseconds after release, the line is seen high and afterwards seen low. A line that stays low, or one that stays high, leaves it at 0.
- R3: Every write or read slot lasts SLOT_US (75) microseconds. The next slot starts in the cycle after the previous one ends.
- R4: A write slot for a 1 and every read slot pull the line low for LOW1_US (2) microseconds at the start of the slot. A write slot for a 0 pulls it low for LOW0_US (65) microseconds.
- R5: In a read slot the bit takes the level of `busIn` sampled at SAMPLE_US (13) microseconds after the slot start. A high level gives 1.
- R6: `cmdLen` value n selects n+1 bits. Bit k of the transfer is `cmdData[k]` on a write and lands in `rdData[k]` on a read, so bit 0 goes first. `rdData` is cleared when a read is accepted.
- R7: `busy` is high from the cycle after acceptance until completion. `done` is a single-cycle pulse in the first cycle with `busy` low. A command presented while `busy` is high is ignored.
- R8: A write with `cmdPower` set raises `busPullHi` in the cycle after its last slot ends. Any accepted command, including depower (`cmdOp` 3), clears it. A depower command pulses `done` in the next cycle and never raises `busy`.
- R9: `busPullHi` is never high while `busy` is high, so resets and reads always run in open-drain mode. It is never high together with `busDrvLow`.
- R10: After `rstN` the block is idle, with `busDrvLow`, `busPullHi`, `busy`, `done`, `presence` and `rdData` all at 0.

The `cmdOp` encodings are: 0 reset, 1 write, 2 read, 3 depower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken only while idle |
| cmdOp | input | 2 | 0 reset, 1 write, 2 read, 3 depower |
| cmdLen | input | LEN_W (3) | Number of bits minus one |
| cmdData | input | MAX_BITS (8) | Write data, bit 0 first |
| cmdPower | input | 1 | Strong pull-up after the last write slot |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | MAX_BITS (8) | Assembled read bits |
| presence | output | 1 | Presence answer of the last reset |
| busIn | input | 1 | Sampled wire level |
| busDrvLow | output | 1 | Pull the wire low |
| busPullHi | output | 1 | Drive the wire actively high |

## Verification
With K clocks per microsecond and acceptance at edge E, the first driven cycle is the one right after E. A phase of D microseconds ends on the edge that closes its D*K-th cycle. A read bit is taken at cycle 13K-1 of its slot. Presence is judged on the edges of cycles 0 to 60K-1 of the release phase. `done` appears in the cycle after the final phase edge, or in the cycle after E for a depower. The bench holds a behavioural model that counts those same cycles in integers. The model steps on the falling edge, after that cycle's inputs have settled, and every output is compared against it at that point. Directed checks then measure low-pulse widths and slot spacing in cycles, and they check the read and presence results once `done` is seen.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_RESET   = 2'd0,
    OP_WRITE   = 2'd1,
    OP_READ    = 2'd2,
    OP_DEPOWER = 2'd3
  } owOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture length and write data, clear bit index
    logic clrRd;     // clear read register
    logic clrPres;   // clear presence and rise detector
    logic presWin;   // presence window open this cycle
    logic restart;   // restart the microsecond timer
    logic sampleRd;  // take the read bit now
    logic nextBit;   // advance to next bit
    logic setPull;   // enable strong pull-up
    logic clrPull;   // disable strong pull-up
  } owStrobe_t;

endpackage

// File: rtl/owm_dpath.sv
module owm_dpath
  import owm_pkg::*;
#(
  parameter int CLK_PER_US = 200,
  parameter int US_W       = 9,
  parameter int DIV_W      = 8,
  parameter int MAX_BITS   = 8,
  parameter int LEN_W      = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  owStrobe_t           stb,
  input  logic [LEN_W-1:0]    cmdLen,
  input  logic [MAX_BITS-1:0] cmdData,
  input  logic                busIn,
  output logic [US_W-1:0]     usCnt,
  output logic                usTick,
  output logic                curBit,
  output logic                lastBit,
  output logic [MAX_BITS-1:0] rdData,
  output logic                presence,
  output logic                pullHi
);

  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0]    divCnt;
  logic [LEN_W-1:0]    bitIdx;
  logic [LEN_W-1:0]    lenReg;
  logic [MAX_BITS-1:0] shReg;
  logic                sawHigh;

  assign usTick  = (divCnt == DIV_END);
  assign curBit  = shReg[0];
  assign lastBit = (bitIdx == lenReg);

  // microsecond timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      usCnt  <= '0;
    end else if (stb.restart) begin
      divCnt <= '0;
      usCnt  <= '0;
    end else if (usTick) begin
      divCnt <= '0;
      usCnt  <= usCnt + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // bit sequencing, LSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx <= '0;
      lenReg <= '0;
      shReg  <= '0;
    end else if (stb.load) begin
      bitIdx <= '0;
      lenReg <= cmdLen;
      shReg  <= cmdData;
    end else if (stb.nextBit) begin
      bitIdx <= bitIdx + 1'b1;
      shReg  <= shReg >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdData <= '0;
    else if (stb.clrRd)    rdData <= '0;
    else if (stb.sampleRd) rdData[bitIdx] <= busIn;
  end

  // presence: a rise after release followed by a device pulling low
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrPres) begin
      presence <= 1'b0;
      sawHigh  <= 1'b0;
    end else if (stb.presWin) begin
      if (busIn)        sawHigh  <= 1'b1;
      else if (sawHigh) presence <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pullHi <= 1'b0;
    else if (stb.clrPull) pullHi <= 1'b0;
    else if (stb.setPull) pullHi <= 1'b1;
  end

  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= lenReg);

  a_r2_pres_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clrPres && !stb.presWin) |=> $stable(presence));

endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int US_W        = 9,
  parameter int RST_LOW_US  = 480,
  parameter int RST_REL_US  = 480,
  parameter int PRES_WIN_US = 60,
  parameter int SLOT_US     = 75,
  parameter int LOW1_US     = 2,
  parameter int LOW0_US     = 65,
  parameter int SAMPLE_US   = 13
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic            cmdPower,
  input  logic [US_W-1:0] usCnt,
  input  logic            usTick,
  input  logic            curBit,
  input  logic            lastBit,
  output owStrobe_t       stb,
  output logic            busy,
  output logic            done,
  output logic            drvLow
);

  localparam logic [US_W-1:0] RL_END  = US_W'(RST_LOW_US - 1);
  localparam logic [US_W-1:0] RR_END  = US_W'(RST_REL_US - 1);
  localparam logic [US_W-1:0] SL_END  = US_W'(SLOT_US - 1);
  localparam logic [US_W-1:0] SMP_END = US_W'(SAMPLE_US - 1);
  localparam logic [US_W-1:0] PW_LEN  = US_W'(PRES_WIN_US);
  localparam logic [US_W-1:0] L1_LEN  = US_W'(LOW1_US);
  localparam logic [US_W-1:0] L0_LEN  = US_W'(LOW0_US);

  typedef enum logic [1:0] {S_IDLE, S_RLOW, S_RREL, S_SLOT} ctrlState_e;

  ctrlState_e      state, nxt;
  owOp_e           op;
  logic            isRead, powerReq, doneNxt;
  logic [US_W-1:0] lowLen;

  assign op     = owOp_e'(cmdOp);
  assign busy   = (state != S_IDLE);
  assign lowLen = (isRead || curBit) ? L1_LEN : L0_LEN;

  always_comb begin
    stb     = '0;
    nxt     = state;
    doneNxt = 1'b0;
    drvLow  = 1'b0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        stb.clrPull = 1'b1;
        unique case (op)
          OP_RESET:   begin stb.restart = 1'b1; stb.clrPres = 1'b1; nxt = S_RLOW; end
          OP_WRITE:   begin stb.restart = 1'b1; stb.load = 1'b1; nxt = S_SLOT; end
          OP_READ:    begin stb.restart = 1'b1; stb.load = 1'b1; stb.clrRd = 1'b1; nxt = S_SLOT; end
          OP_DEPOWER: doneNxt = 1'b1;
        endcase
      end
      S_RLOW: begin
        drvLow = 1'b1;
        if (usTick && usCnt == RL_END) begin
          stb.restart = 1'b1;
          nxt = S_RREL;
        end
      end
      S_RREL: begin
        stb.presWin = (usCnt < PW_LEN);
        if (usTick && usCnt == RR_END) begin
          nxt = S_IDLE;
          doneNxt = 1'b1;
        end
      end
      S_SLOT: begin
        drvLow = (usCnt < lowLen);
        stb.sampleRd = isRead && usTick && (usCnt == SMP_END);
        if (usTick && usCnt == SL_END) begin
          if (lastBit) begin
            nxt = S_IDLE;
            doneNxt = 1'b1;
            stb.setPull = !isRead && powerReq;
          end else begin
            stb.nextBit = 1'b1;
            stb.restart = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      isRead   <= 1'b0;
      powerReq <= 1'b0;
    end else begin
      state <= nxt;
      done  <= doneNxt;
      if (state == S_IDLE && cmdValid) begin
        isRead   <= (op == OP_READ);
        powerReq <= cmdPower;
      end
    end
  end

  a_r7_fall_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SLOT) |-> (usCnt < US_W'(SLOT_US)));

endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int CLK_PER_US  = 200,
  parameter int RST_LOW_US  = 480,
  parameter int RST_REL_US  = 480,
  parameter int PRES_WIN_US = 60,
  parameter int SLOT_US     = 75,
  parameter int LOW1_US     = 2,
  parameter int LOW0_US     = 65,
  parameter int SAMPLE_US   = 13,
  parameter int MAX_BITS    = 8,
  localparam int LEN_W      = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [1:0]          cmdOp,
  input  logic [LEN_W-1:0]    cmdLen,
  input  logic [MAX_BITS-1:0] cmdData,
  input  logic                cmdPower,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rdData,
  output logic                presence,
  input  logic                busIn,
  output logic                busDrvLow,
  output logic                busPullHi
);

  localparam int US_MAX0 = (RST_LOW_US > RST_REL_US) ? RST_LOW_US : RST_REL_US;
  localparam int US_MAX  = (US_MAX0 > SLOT_US) ? US_MAX0 : SLOT_US;
  localparam int US_W    = $clog2(US_MAX + 1);
  localparam int DIV_W   = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  owStrobe_t       stb;
  logic [US_W-1:0] usCnt;
  logic            usTick, curBit, lastBit;

  owm_ctrl #(
    .US_W(US_W), .RST_LOW_US(RST_LOW_US), .RST_REL_US(RST_REL_US),
    .PRES_WIN_US(PRES_WIN_US), .SLOT_US(SLOT_US), .LOW1_US(LOW1_US),
    .LOW0_US(LOW0_US), .SAMPLE_US(SAMPLE_US)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPower(cmdPower), .usCnt(usCnt), .usTick(usTick), .curBit(curBit),
    .lastBit(lastBit), .stb(stb), .busy(busy), .done(done), .drvLow(busDrvLow)
  );

  owm_dpath #(
    .CLK_PER_US(CLK_PER_US), .US_W(US_W), .DIV_W(DIV_W),
    .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdLen(cmdLen), .cmdData(cmdData),
    .busIn(busIn), .usCnt(usCnt), .usTick(usTick), .curBit(curBit),
    .lastBit(lastBit), .rdData(rdData), .presence(presence), .pullHi(busPullHi)
  );

  a_r9_no_fight: assert property (@(posedge clk) disable iff (!rstN)
    !(busDrvLow && busPullHi));

  a_r9_pull_idle: assert property (@(posedge clk) disable iff (!rstN)
    busPullHi |-> !busy);

endmodule

// File: tb/tb_owm_master.sv
`timescale 1ns/1ps
module tb_owm_master;

  localparam int K = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [2:0] cmdLen = 3'd0;
  logic [7:0] cmdData = 8'd0;
  logic       cmdPower = 1'b0;
  logic       busy, done, presence, busDrvLow, busPullHi;
  logic [7:0] rdData;
  logic       devLow = 1'b0;
  logic       busIn;

  assign busIn = !(busDrvLow || devLow);

  always #2.5 clk = ~clk;

  owm_master #(.CLK_PER_US(K)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdLen(cmdLen), .cmdData(cmdData), .cmdPower(cmdPower), .busy(busy),
    .done(done), .rdData(rdData), .presence(presence), .busIn(busIn),
    .busDrvLow(busDrvLow), .busPullHi(busPullHi)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- device emulation ----------------
  int devMode = 0;     // 0 silent, 1 read responder, 2 presence answer, 3 stuck low
  bit devBits[$];
  int devCnt = 0, devWait = 0;
  logic prevDrv = 1'b0;

  always @(posedge clk) begin
    #1;
    if (devMode == 1 && busDrvLow && !prevDrv && devBits.size() > 0) begin
      if (!devBits.pop_front()) devCnt = 30 * K;
    end
    if (devMode == 2 && !busDrvLow && prevDrv) devWait = 20 * K;
    if (devWait > 0) begin
      devWait--;
      if (devWait == 0) devCnt = 100 * K;
    end
    prevDrv = busDrvLow;
    devLow = (devMode == 3) || (devCnt > 0);
    if (devCnt > 0) devCnt--;
  end

  // ---------------- cycle reference model ----------------
  int mSt = 0, mCyc = 0, mBit = 0, mN = 1;
  bit mDone = 0, mPull = 0, mPres = 0, mSaw = 0, mIsRd = 0, mPow = 0;
  logic [7:0] mRd = 8'd0, mData = 8'd0;

  function automatic bit modelDrv();
    if (mSt == 1) return 1'b1;
    if (mSt == 3) return mCyc < (((mIsRd || mData[mBit]) ? 2 : 65) * K);
    return 1'b0;
  endfunction

  // monitors
  int cycN = 0, lowRun = 0;
  int lowW[$];
  int starts[$];
  logic lastDrvN = 1'b0;

  always @(negedge clk) begin
    cycN++;
    if (busDrvLow) begin
      if (!lastDrvN) starts.push_back(cycN);
      lowRun++;
    end else if (lowRun > 0) begin
      lowW.push_back(lowRun);
      lowRun = 0;
    end
    lastDrvN = busDrvLow;
    if (!rstN) begin
      mSt = 0; mDone = 0; mPull = 0; mPres = 0; mSaw = 0; mRd = 8'd0;
    end else begin
      chk("R7 busy model", busy, mSt != 0);
      chk("R7 done model", done, mDone);
      chk("R1/R3/R4 busDrvLow model", busDrvLow, modelDrv());
      chk("R8 busPullHi model", busPullHi, mPull);
      chk("R2 presence model", presence, mPres);
      chk("R5 rdData model", rdData, mRd);
      mDone = 0;
      case (mSt)
        0: if (cmdValid) begin
          mPull = 0;
          case (cmdOp)
            2'd0: begin mSt = 1; mCyc = 0; mPres = 0; mSaw = 0; end
            2'd1, 2'd2: begin
              mSt = 3; mCyc = 0; mBit = 0; mN = cmdLen + 1; mData = cmdData;
              mIsRd = (cmdOp == 2'd2); mPow = cmdPower;
              if (mIsRd) mRd = 8'd0;
            end
            default: mDone = 1;
          endcase
        end
        1: if (mCyc == 480 * K - 1) begin mSt = 2; mCyc = 0; end else mCyc++;
        2: begin
          if (mCyc < 60 * K) begin
            if (busIn) mSaw = 1;
            else if (mSaw) mPres = 1;
          end
          if (mCyc == 480 * K - 1) begin mSt = 0; mDone = 1; end else mCyc++;
        end
        3: begin
          if (mIsRd && mCyc == 13 * K - 1) mRd[mBit] = busIn;
          if (mCyc == 75 * K - 1) begin
            if (mBit == mN - 1) begin
              mSt = 0; mDone = 1;
              if (!mIsRd && mPow) mPull = 1;
            end else begin
              mBit++; mCyc = 0;
            end
          end else mCyc++;
        end
        default: ;
      endcase
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input int op, input int len, input int data, input bit pow);
    @(posedge clk); #1;
    cmdValid = 1'b1; cmdOp = 2'(op); cmdLen = 3'(len); cmdData = 8'(data); cmdPower = pow;
    @(posedge clk); #1;
    cmdValid = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  task automatic clearMon();
    lowW.delete();
    starts.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 busDrvLow", busDrvLow, 0);
    chk("R10 busPullHi", busPullHi, 0);
    chk("R10 presence", presence, 0);
    chk("R10 rdData", rdData, 0);

    // R1, R2: reset with an answering device
    devMode = 2; clearMon();
    issue(0, 0, 0, 0); waitDone();
    chk("R2 presence answered", presence, 1);
    chk("R1 reset low width", lowW.size() > 0 ? lowW[0] : -1, 480 * K);
    @(negedge clk);
    chk("R7 done single cycle", done, 0);

    // R2: silent bus, then stuck-low bus
    devMode = 0;
    issue(0, 0, 0, 0); waitDone();
    chk("R2 presence silent", presence, 0);
    devMode = 3;
    issue(0, 0, 0, 0); waitDone();
    chk("R2 presence stuck low", presence, 0);
    devMode = 0;
    repeat (2) @(negedge clk);

    // R3, R4, R6: write 0xA5, 8 bits
    clearMon();
    issue(1, 7, 8'hA5, 0); waitDone();
    chk("R6 write slot count", lowW.size(), 8);
    for (int i = 0; i < 8 && i < lowW.size(); i++)
      chk("R4 R6 write low width", lowW[i], ((8'hA5 >> i) & 1) ? 2 * K : 65 * K);
    for (int i = 1; i < starts.size(); i++)
      chk("R3 slot spacing", starts[i] - starts[i-1], 75 * K);
    chk("R8 no pull without power", busPullHi, 0);

    // R5: read 0x3C
    devMode = 1; devBits.delete();
    for (int i = 0; i < 8; i++) devBits.push_back(bit'((8'h3C >> i) & 1));
    clearMon();
    issue(2, 7, 0, 0); waitDone();
    chk("R5 read byte", rdData, 8'h3C);
    for (int i = 0; i < lowW.size(); i++) chk("R4 read low width", lowW[i], 2 * K);

    // R6: read 3 bits 1,0,1
    devBits.delete();
    devBits.push_back(1'b1); devBits.push_back(1'b0); devBits.push_back(1'b1);
    clearMon();
    issue(2, 2, 0, 0); waitDone();
    chk("R6 short read value", rdData, 5);
    chk("R6 short read slots", lowW.size(), 3);

    // R8: powered write, then depower
    issue(1, 7, 8'h0F, 1); waitDone();
    chk("R8 pull after powered write", busPullHi, 1);
    repeat (10) @(negedge clk);
    chk("R8 pull held", busPullHi, 1);
    issue(3, 0, 0, 0);
    chk("R8 depower not busy", busy, 0);
    chk("R8 depower done", done, 1);
    chk("R8 depower released", busPullHi, 0);

    // R9: powered 1-bit write then a read clears the pull-up
    issue(1, 0, 1, 1); waitDone();
    chk("R8 pull after 1-bit write", busPullHi, 1);
    devBits.delete(); devBits.push_back(1'b1);
    issue(2, 0, 0, 0);
    chk("R9 open drain during read", busPullHi, 0);
    waitDone();
    chk("R9 no pull after read", busPullHi, 0);
    chk("R5 single read bit", rdData, 1);

    // R7: command while busy is ignored
    devMode = 0; clearMon();
    issue(1, 7, 8'h00, 0);
    repeat (100) @(negedge clk);
    issue(2, 0, 0, 0);
    waitDone();
    chk("R7 ignored read kept data", rdData, 1);
    chk("R7 write slots only", lowW.size(), 8);
    @(negedge clk);
    chk("R7 idle after", busy, 0);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule